// File: doc/BRIEF.md
# Flash Page Layout Sequencer

This block produces the physical byte order of one flash page. A page holds a number of data packets, and each packet is followed by its error-correction parity bytes. A small metadata field comes before the first packet. A bad-block-marker window is placed at a programmed physical offset that lies inside the final packet, so that packet is cut into a leading part and a trailing part. The block computes none of the parity. For each physical byte slot it reports what belongs there and the logical index of that byte.

A `start` pulse while the block is idle latches the page geometry: packet data size, ECC strength, packet count, metadata size, marker offset, marker size and direction. From the next cycle on, the block emits one slot per cycle. Each slot carries a kind code and four running indices: the physical position, the logical data index, the logical spare-area index and the packet number. On the spare side the logical order is the marker bytes first, then the metadata, then the parity of each packet in packet order. On a program (write) page, the metadata slots are flagged to be filled with all-ones. A one-cycle `done` follows the last parity byte.

Top module: `page_layout_seq`

## Requirements
- R1: A `start` seen while idle begins a page whose first slot is presented on the following cycle. Slots then follow one per cycle with `slot_valid` held high, for exactly meta + steps*(pkt + parity) + marker slots.
- R2: Physical order is all metadata slots, then the data of packet 0 and the parity of packet 0, then the data and parity of each following packet. The kind codes on `slot_kind` are data=0, metadata=1, parity=2, marker=3.
- R3: Each packet is followed by ceil(strength*15/8) parity slots.
- R4: Inside the last packet, the marker window (`mark_size` slots) is inserted at the slot whose physical index equals `mark_offset`. The leading part holds the bytes before that offset and the trailing part holds the rest of the packet. When the leading part is the whole packet, the marker sits between that packet's data and its parity.
- R5: `phys_idx` is 0 on the first slot and rises by one on every slot. It is 0 when no slot is valid.
- R6: On data slots, `data_idx` is the logical data byte index, contiguous over packets and across the marker split (0 to steps*pkt-1). It is 0 on every other slot.
- R7: `spare_idx` is j for marker byte j, mark_size+j for metadata byte j, and mark_size+meta+k*parity+j for parity byte j of packet k. It is 0 on data slots and when idle.
- R8: `pkt_idx` gives the packet number on data, parity and marker slots. It is 0 on metadata slots and when idle.
- R9: `fill_ones` is high exactly on the metadata slots of a page started with `write_mode`=1.
- R10: `done` is high for exactly one cycle, the cycle after the last parity slot of the last packet.
- R11: A `start` pulse during a page, and changes to the geometry inputs during a page, have no effect on that page's slots.
- R12: During reset and right after it, `slot_valid`, `done`, `fill_ones` and all indices are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a page (honoured only when idle) |
| write_mode | input | 1 | 1 = program page, 0 = read page |
| pkt_size | input | PKT_W | Data bytes per packet |
| ecc_strength | input | STR_W | Correctable bits per packet |
| step_count | input | STEP_W | Packets per page |
| meta_size | input | META_W | Metadata bytes before packet 0 |
| mark_offset | input | IDX_W | Physical offset of the marker window |
| mark_size | input | MARK_W | Marker window length |
| slot_valid | output | 1 | A slot is presented this cycle |
| slot_kind | output | 2 | Slot kind code |
| phys_idx | output | IDX_W | Physical byte position |
| data_idx | output | IDX_W | Logical data index |
| spare_idx | output | IDX_W | Logical spare-area index |
| pkt_idx | output | STEP_W | Packet number |
| fill_ones | output | 1 | Metadata byte to be written as all-ones |
| done | output | 1 | Page sequence finished |

## Verification
The properties assume a legal geometry. Every size and count is at least 1. The marker offset falls after the first data byte of the last packet and no later than the slot just past its final data byte. The sizes are also small enough that every index fits its port. Each page the bench starts is built by hand to meet these rules: the start of the last packet is worked out from the metadata, packet and parity sizes, and the offset is placed one byte to a full packet beyond it. The only out-of-range stimulus is the geometry driven during a page that is already running, and that geometry must be ignored.

// File: rtl/page_layout_pkg.sv
package page_layout_pkg;

    typedef enum logic [1:0] {
        SLOT_DATA   = 2'd0,
        SLOT_META   = 2'd1,
        SLOT_PARITY = 2'd2,
        SLOT_MARK   = 2'd3
    } slot_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_META,
        ST_DATA,
        ST_PARITY,
        ST_MARK
    } seq_state_e;

endpackage

// File: rtl/page_parity_len.sv
module page_parity_len #(
    parameter int STR_W = 6,
    parameter int PAR_W = STR_W + 1
) (
    input  logic [STR_W-1:0] strength,
    output logic [PAR_W-1:0] par_len
);
    localparam int PROD_W = STR_W + 4;
    localparam int BITS_PER_SYM = 15;

    logic [PROD_W-1:0] bits_total;

    // ceil(strength * 15 / 8)
    always_comb begin
        bits_total = PROD_W'(strength) * PROD_W'(BITS_PER_SYM) + PROD_W'(7);
        par_len    = bits_total[PAR_W+2:3];
    end
endmodule

// File: rtl/page_cfg_latch.sv
module page_cfg_latch #(
    parameter int IDX_W  = 16,
    parameter int PKT_W  = 12,
    parameter int PAR_W  = 7,
    parameter int STEP_W = 5,
    parameter int META_W = 4,
    parameter int MARK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              wr_in,
    input  logic [PKT_W-1:0]  pkt_in,
    input  logic [PAR_W-1:0]  par_in,
    input  logic [STEP_W-1:0] steps_in,
    input  logic [META_W-1:0] meta_in,
    input  logic [IDX_W-1:0]  moff_in,
    input  logic [MARK_W-1:0] msz_in,
    output logic              wr_q,
    output logic [PKT_W-1:0]  pkt_q,
    output logic [PAR_W-1:0]  par_q,
    output logic [STEP_W-1:0] steps_q,
    output logic [META_W-1:0] meta_q,
    output logic [IDX_W-1:0]  moff_q,
    output logic [MARK_W-1:0] msz_q
);
    typedef struct packed {
        logic              wr;
        logic [PKT_W-1:0]  pkt;
        logic [PAR_W-1:0]  par;
        logic [STEP_W-1:0] steps;
        logic [META_W-1:0] meta;
        logic [IDX_W-1:0]  moff;
        logic [MARK_W-1:0] msz;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (load) begin
            cfg_d.wr    = wr_in;
            cfg_d.pkt   = pkt_in;
            cfg_d.par   = par_in;
            cfg_d.steps = steps_in;
            cfg_d.meta  = meta_in;
            cfg_d.moff  = moff_in;
            cfg_d.msz   = msz_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign wr_q    = cfg_q.wr;
    assign pkt_q   = cfg_q.pkt;
    assign par_q   = cfg_q.par;
    assign steps_q = cfg_q.steps;
    assign meta_q  = cfg_q.meta;
    assign moff_q  = cfg_q.moff;
    assign msz_q   = cfg_q.msz;
endmodule

// File: rtl/page_layout_fsm.sv
module page_layout_fsm
    import page_layout_pkg::*;
#(
    parameter int IDX_W  = 16,
    parameter int PKT_W  = 12,
    parameter int PAR_W  = 7,
    parameter int STEP_W = 5,
    parameter int META_W = 4,
    parameter int MARK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [MARK_W-1:0] msz_in,
    input  logic [PKT_W-1:0]  pkt_q,
    input  logic [PAR_W-1:0]  par_q,
    input  logic [STEP_W-1:0] steps_q,
    input  logic [META_W-1:0] meta_q,
    input  logic [IDX_W-1:0]  moff_q,
    input  logic [MARK_W-1:0] msz_q,
    output logic              accept,
    output seq_state_e        state,
    output logic [MARK_W-1:0] mark_cnt,
    output logic [STEP_W-1:0] pkt_num,
    output logic [IDX_W-1:0]  phys_pos,
    output logic [IDX_W-1:0]  data_pos,
    output logic [IDX_W-1:0]  spare_pos,
    output logic              done_pulse
);
    localparam int CNT_A = (PKT_W > PAR_W) ? PKT_W : PAR_W;
    localparam int CNT_W = (CNT_A > META_W) ? CNT_A : META_W;

    typedef struct packed {
        seq_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [MARK_W-1:0] mcnt;
        logic [STEP_W-1:0] pkt;
        logic [IDX_W-1:0]  phys;
        logic [IDX_W-1:0]  data;
        logic [IDX_W-1:0]  spare;
        logic              mark_done;
        logic              done;
    } seq_t;

    seq_t s_d, s_q;

    logic cnt_meta_end, cnt_pkt_end, cnt_par_end, last_pkt, mark_hit, mcnt_end;

    always_comb begin
        cnt_meta_end = (s_q.cnt == CNT_W'(meta_q) - CNT_W'(1));
        cnt_pkt_end  = (s_q.cnt == CNT_W'(pkt_q) - CNT_W'(1));
        cnt_par_end  = (s_q.cnt == CNT_W'(par_q) - CNT_W'(1));
        last_pkt     = (s_q.pkt == steps_q - STEP_W'(1));
        mark_hit     = last_pkt && !s_q.mark_done
                       && (s_q.phys + IDX_W'(1) == moff_q);
        mcnt_end     = (s_q.mcnt == msz_q - MARK_W'(1));
        accept       = start && (s_q.st == ST_IDLE);

        s_d      = s_q;
        s_d.done = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.st        = ST_META;
                    s_d.cnt       = '0;
                    s_d.mcnt      = '0;
                    s_d.pkt       = '0;
                    s_d.phys      = '0;
                    s_d.data      = '0;
                    s_d.spare     = IDX_W'(msz_in);
                    s_d.mark_done = 1'b0;
                end
            end
            ST_META: begin
                s_d.phys  = s_q.phys + IDX_W'(1);
                s_d.spare = s_q.spare + IDX_W'(1);
                if (cnt_meta_end) begin
                    s_d.st  = ST_DATA;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + CNT_W'(1);
                end
            end
            ST_DATA: begin
                s_d.phys = s_q.phys + IDX_W'(1);
                s_d.data = s_q.data + IDX_W'(1);
                if (mark_hit) begin
                    s_d.st   = ST_MARK;
                    s_d.mcnt = '0;
                end else if (cnt_pkt_end) begin
                    s_d.st  = ST_PARITY;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + CNT_W'(1);
                end
            end
            ST_MARK: begin
                s_d.phys = s_q.phys + IDX_W'(1);
                if (mcnt_end) begin
                    s_d.mark_done = 1'b1;
                    if (cnt_pkt_end) begin
                        s_d.st  = ST_PARITY;
                        s_d.cnt = '0;
                    end else begin
                        s_d.st  = ST_DATA;
                        s_d.cnt = s_q.cnt + CNT_W'(1);
                    end
                end else begin
                    s_d.mcnt = s_q.mcnt + MARK_W'(1);
                end
            end
            ST_PARITY: begin
                s_d.phys  = s_q.phys + IDX_W'(1);
                s_d.spare = s_q.spare + IDX_W'(1);
                if (cnt_par_end) begin
                    s_d.cnt = '0;
                    if (last_pkt) begin
                        s_d.st   = ST_IDLE;
                        s_d.done = 1'b1;
                    end else begin
                        s_d.st  = ST_DATA;
                        s_d.pkt = s_q.pkt + STEP_W'(1);
                    end
                end else begin
                    s_d.cnt = s_q.cnt + CNT_W'(1);
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign state      = s_q.st;
    assign mark_cnt   = s_q.mcnt;
    assign pkt_num    = s_q.pkt;
    assign phys_pos   = s_q.phys;
    assign data_pos   = s_q.data;
    assign spare_pos  = s_q.spare;
    assign done_pulse = s_q.done;
endmodule

// File: rtl/page_layout_seq.sv
module page_layout_seq
    import page_layout_pkg::*;
#(
    parameter int IDX_W  = 16,
    parameter int PKT_W  = 12,
    parameter int STR_W  = 6,
    parameter int STEP_W = 5,
    parameter int META_W = 4,
    parameter int MARK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              write_mode,
    input  logic [PKT_W-1:0]  pkt_size,
    input  logic [STR_W-1:0]  ecc_strength,
    input  logic [STEP_W-1:0] step_count,
    input  logic [META_W-1:0] meta_size,
    input  logic [IDX_W-1:0]  mark_offset,
    input  logic [MARK_W-1:0] mark_size,
    output logic              slot_valid,
    output logic [1:0]        slot_kind,
    output logic [IDX_W-1:0]  phys_idx,
    output logic [IDX_W-1:0]  data_idx,
    output logic [IDX_W-1:0]  spare_idx,
    output logic [STEP_W-1:0] pkt_idx,
    output logic              fill_ones,
    output logic              done
);
    localparam int PAR_W = STR_W + 1;

    logic [PAR_W-1:0]  par_len;
    logic              accept;
    logic              wr_q;
    logic [PKT_W-1:0]  pkt_q;
    logic [PAR_W-1:0]  par_q;
    logic [STEP_W-1:0] steps_q;
    logic [META_W-1:0] meta_q;
    logic [IDX_W-1:0]  moff_q;
    logic [MARK_W-1:0] msz_q;
    seq_state_e        state;
    logic [MARK_W-1:0] mark_cnt;
    logic [STEP_W-1:0] pkt_num;
    logic [IDX_W-1:0]  phys_pos, data_pos, spare_pos;

    page_parity_len #(.STR_W(STR_W), .PAR_W(PAR_W)) u_par (
        .strength (ecc_strength),
        .par_len  (par_len)
    );

    page_cfg_latch #(
        .IDX_W(IDX_W), .PKT_W(PKT_W), .PAR_W(PAR_W),
        .STEP_W(STEP_W), .META_W(META_W), .MARK_W(MARK_W)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .wr_in    (write_mode),
        .pkt_in   (pkt_size),
        .par_in   (par_len),
        .steps_in (step_count),
        .meta_in  (meta_size),
        .moff_in  (mark_offset),
        .msz_in   (mark_size),
        .wr_q     (wr_q),
        .pkt_q    (pkt_q),
        .par_q    (par_q),
        .steps_q  (steps_q),
        .meta_q   (meta_q),
        .moff_q   (moff_q),
        .msz_q    (msz_q)
    );

    page_layout_fsm #(
        .IDX_W(IDX_W), .PKT_W(PKT_W), .PAR_W(PAR_W),
        .STEP_W(STEP_W), .META_W(META_W), .MARK_W(MARK_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .msz_in     (mark_size),
        .pkt_q      (pkt_q),
        .par_q      (par_q),
        .steps_q    (steps_q),
        .meta_q     (meta_q),
        .moff_q     (moff_q),
        .msz_q      (msz_q),
        .accept     (accept),
        .state      (state),
        .mark_cnt   (mark_cnt),
        .pkt_num    (pkt_num),
        .phys_pos   (phys_pos),
        .data_pos   (data_pos),
        .spare_pos  (spare_pos),
        .done_pulse (done)
    );

    always_comb begin
        slot_valid = (state != ST_IDLE);
        slot_kind  = SLOT_DATA;
        data_idx   = '0;
        spare_idx  = '0;
        case (state)
            ST_META: begin
                slot_kind = SLOT_META;
                spare_idx = spare_pos;
            end
            ST_DATA: begin
                slot_kind = SLOT_DATA;
                data_idx  = data_pos;
            end
            ST_PARITY: begin
                slot_kind = SLOT_PARITY;
                spare_idx = spare_pos;
            end
            ST_MARK: begin
                slot_kind = SLOT_MARK;
                spare_idx = IDX_W'(mark_cnt);
            end
            default: slot_kind = SLOT_DATA;
        endcase
        phys_idx  = slot_valid ? phys_pos : '0;
        pkt_idx   = slot_valid ? pkt_num : '0;
        fill_ones = (state == ST_META) && wr_q;
    end
endmodule

// File: rtl/page_layout_checker.sv
module page_layout_checker #(
    parameter int IDX_W  = 16,
    parameter int STEP_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              slot_valid,
    input logic [1:0]        slot_kind,
    input logic [IDX_W-1:0]  phys_idx,
    input logic [IDX_W-1:0]  data_idx,
    input logic [STEP_W-1:0] pkt_idx,
    input logic              fill_ones,
    input logic              done
);
    assert_first_slot_meta_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid && !$past(slot_valid)) |-> (slot_kind == 2'd1 && phys_idx == '0));

    assert_phys_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid && $past(slot_valid)) |-> (phys_idx == $past(phys_idx) + IDX_W'(1)));

    assert_data_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid && slot_kind == 2'd0 && $past(slot_valid) && $past(slot_kind) == 2'd0)
        |-> (data_idx == $past(data_idx) + IDX_W'(1)));

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_valid |-> (phys_idx == '0 && pkt_idx == '0 && !fill_ones));

    assert_fill_on_meta_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fill_ones |-> (slot_valid && slot_kind == 2'd1));

    assert_done_after_parity_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(slot_valid) && $past(slot_kind) == 2'd2 && !slot_valid));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind page_layout_seq page_layout_checker #(.IDX_W(IDX_W), .STEP_W(STEP_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_valid (slot_valid),
    .slot_kind  (slot_kind),
    .phys_idx   (phys_idx),
    .data_idx   (data_idx),
    .pkt_idx    (pkt_idx),
    .fill_ones  (fill_ones),
    .done       (done)
);

// File: tb/page_layout_seq_test.sv
`timescale 1ns/1ps
module page_layout_seq_test;
    localparam int IDX_W = 16, PKT_W = 12, STR_W = 6, STEP_W = 5, META_W = 4, MARK_W = 4;

    logic clk = 0;
    logic rst_n = 0;
    logic start = 0, write_mode = 0;
    logic [PKT_W-1:0]  pkt_size = '0;
    logic [STR_W-1:0]  ecc_strength = '0;
    logic [STEP_W-1:0] step_count = '0;
    logic [META_W-1:0] meta_size = '0;
    logic [IDX_W-1:0]  mark_offset = '0;
    logic [MARK_W-1:0] mark_size = '0;
    logic              slot_valid, fill_ones, done;
    logic [1:0]        slot_kind;
    logic [IDX_W-1:0]  phys_idx, data_idx, spare_idx;
    logic [STEP_W-1:0] pkt_idx;

    always #2.5 clk = ~clk;

    page_layout_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .write_mode(write_mode),
        .pkt_size(pkt_size), .ecc_strength(ecc_strength), .step_count(step_count),
        .meta_size(meta_size), .mark_offset(mark_offset), .mark_size(mark_size),
        .slot_valid(slot_valid), .slot_kind(slot_kind), .phys_idx(phys_idx),
        .data_idx(data_idx), .spare_idx(spare_idx), .pkt_idx(pkt_idx),
        .fill_ones(fill_ones), .done(done)
    );

    typedef struct {
        int kind; int phys; int data; int spare; int pkt; int fill;
    } slot_t;

    slot_t q[$];
    slot_t cur;
    int cur_valid = 0;
    int exp_done = 0;
    int checks = 0;
    int failures = 0;
    bit stray_win = 0;

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic void push(int kind, int phys, int data, int spare, int pkt, int fill);
        slot_t s;
        s.kind = kind; s.phys = phys; s.data = data;
        s.spare = spare; s.pkt = pkt; s.fill = fill;
        q.push_back(s);
    endfunction

    // Behavioural page builder from the requirements
    function automatic void build_page();
        int p = 0, sp = int'(mark_size), d = 0;
        int par = (int'(ecc_strength) * 15 + 7) / 8;
        int lead;
        for (int j = 0; j < int'(meta_size); j++) push(1, p++, 0, sp++, 0, int'(write_mode));
        for (int k = 0; k < int'(step_count); k++) begin
            if (k < int'(step_count) - 1) begin
                for (int j = 0; j < int'(pkt_size); j++) push(0, p++, d++, 0, k, 0);
            end else begin
                lead = int'(mark_offset) - p;
                for (int j = 0; j < lead; j++) push(0, p++, d++, 0, k, 0);
                for (int j = 0; j < int'(mark_size); j++) push(3, p++, 0, j, k, 0);
                for (int j = 0; j < int'(pkt_size) - lead; j++) push(0, p++, d++, 0, k, 0);
            end
            for (int j = 0; j < par; j++) push(2, p++, 0, sp++, k, 0);
        end
    endfunction

    always @(posedge clk) begin
        int was;
        if (!rst_n) begin
            q.delete(); cur_valid = 0; exp_done = 0;
        end else begin
            was = cur_valid;
            if (!was && start) build_page();
            if (q.size() > 0) begin cur = q.pop_front(); cur_valid = 1; end
            else cur_valid = 0;
            exp_done = was && !cur_valid;
        end
    end

    always @(negedge clk) begin
        string tk;
        if (!rst_n) begin
            chk("R12", "valid", int'(slot_valid), 0);
            chk("R12", "done", int'(done), 0);
            chk("R12", "phys", int'(phys_idx), 0);
            chk("R12", "spare", int'(spare_idx), 0);
        end else if (cur_valid) begin
            tk = (cur.kind == 3) ? "R4" : (cur.kind == 2) ? "R3" : "R2";
            chk(stray_win ? "R11" : "R1", "valid", int'(slot_valid), 1);
            chk(stray_win ? "R11" : tk, "kind", int'(slot_kind), cur.kind);
            chk(stray_win ? "R11" : "R5", "phys", int'(phys_idx), cur.phys);
            chk(stray_win ? "R11" : "R6", "data_idx", int'(data_idx), cur.data);
            chk(stray_win ? "R11" : "R7", "spare_idx", int'(spare_idx), cur.spare);
            chk(stray_win ? "R11" : "R8", "pkt_idx", int'(pkt_idx), cur.pkt);
            chk(stray_win ? "R11" : "R9", "fill_ones", int'(fill_ones), cur.fill);
            chk("R10", "done", int'(done), 0);
        end else begin
            chk("R1", "valid", int'(slot_valid), 0);
            chk("R10", "done", int'(done), exp_done);
            chk("R12", "phys", int'(phys_idx), 0);
            chk("R9", "fill_ones", int'(fill_ones), 0);
        end
    end

    task automatic run_page(bit wr, int pkt, int str, int steps, int meta,
                            int moff, int msz, bit stray);
        @(posedge clk); #1;
        write_mode = wr; pkt_size = PKT_W'(pkt); ecc_strength = STR_W'(str);
        step_count = STEP_W'(steps); meta_size = META_W'(meta);
        mark_offset = IDX_W'(moff); mark_size = MARK_W'(msz);
        start = 1;
        @(posedge clk); #1;
        start = 0;
        if (stray) begin
            // R11: stray start and new geometry while the page runs
            repeat (5) @(posedge clk);
            #1;
            stray_win = 1;
            write_mode = ~wr; pkt_size = 3; ecc_strength = 9; step_count = 4;
            meta_size = 7; mark_offset = 5; mark_size = 5; start = 1;
            @(posedge clk); #1;
            start = 0;
        end
        while (cur_valid || q.size() > 0) @(posedge clk);
        repeat (3) @(posedge clk);
        #1 stray_win = 0;
    endtask

    initial begin
        #500000;
        failures++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        // R4 split: last data starts at 44, marker at 48 (lead 4, trail 12)
        run_page(1, 16, 2, 3, 4, 48, 2, 0);
        // R4 full leading part: marker between data and parity; R11 stray start
        run_page(0, 8, 1, 2, 4, 22, 2, 1);
        // single packet, lead of one byte
        run_page(1, 6, 5, 1, 2, 3, 3, 0);
        // R3 maximum strength: 119 parity bytes
        run_page(0, 4, 63, 2, 4, 128, 1, 0);
        // one-byte packets, lead equals full packet
        run_page(1, 1, 8, 3, 1, 34, 4, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule